// File: doc/BRIEF.md
# Clock Lane High-Speed Entry and Exit Sequencer

This block controls the clock lane of a serial display-link transmitter PHY. It runs on the lane byte clock. When the data-lane logic raises a request, it takes the lane out of the low-power idle state and into continuous high-speed clocking. When the request is dropped, it brings the lane back to idle. Every interval the lane spends in a phase is a count of byte-clock cycles taken from a configuration input.

The data-lane logic uses a level request and acknowledge pair. It holds `hs_req` high for as long as it needs the clock. It may start high-speed data only while `hs_ack` is high. The acknowledge follows the request but never leads it. There is no back-pressure: the request is sampled once per cycle and the sequencer only acts on it in the idle state (to start) and in the clocking state (to stop). Two enables go to the analog front end. Each one can be taken from the state machine or forced from a configuration bit. Power-down and the two soft resets override everything else.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset the lane is idle: `ana_lp_en`=1, `ana_hs_en`=0, `hs_ack`=0, and `lane_status`[2] (idle flag) is 1.
- R2: A request seen while idle starts a low-power lead-in lasting the lpx count, with `ana_lp_en` still 1. Then `ana_hs_en` rises and `ana_lp_en` falls in the same cycle, for the prepare phase, the zero phase and the clocking phase that follow.
- R3: `hs_ack` rises once the lane has been in the clocking phase for the pre count of cycles. It falls in the cycle after the release is taken. If the release comes before that, `hs_ack` never rises.
- R4: After a release, the lane stays in a post phase for the post count, then in a trail phase for the trail count. It then returns to idle with `ana_hs_en` falling and `ana_lp_en` rising in the same cycle.
- R5: A timing count of 0 gives a phase of exactly one cycle.
- R6: A request raised during the trail phase is held. The lane reaches idle, stays there one cycle, and then starts a new entry.
- R7: When `hs_en_sel`=1, `ana_hs_en` follows `hs_en_reg`; when it is 0, the value comes from the state machine.
- R8: When `lp_en_sel`=1, `ana_lp_en` follows `lp_en_reg`; when it is 0, the value comes from the state machine.
- R9: While `pwr_down`=1, both enables are 0 regardless of the overrides. From the next edge the lane is idle and ignores the request. Once `pwr_down` falls, a pending request starts a normal entry.
- R10: `soft_rst_lane` or `soft_rst_phy` returns the lane to idle at the next edge (`hs_ack`=0, `ana_lp_en`=1) and holds it there while the input is asserted.
- R11: `lane_status` is {bias ready at bit 3, idle at bit 2, ultra-low-power at bit 1, high-speed active at bit 0}. Bit 1 is always 0. Bit 0 is 1 from the prepare phase to the end of the trail phase. Bits 2 and 0 are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_lane | input | 1 | Clock-lane soft reset |
| soft_rst_phy | input | 1 | Whole-PHY soft reset |
| pwr_down | input | 1 | Clock-lane and PHY power-down |
| bias_ready | input | 1 | Analog bias ready flag, reported in status |
| hs_req | input | 1 | High-speed clock request from data lanes |
| hs_ack | output | 1 | Clock running and pre-interval elapsed |
| t_lpx | input | TW | Low-power lead-in count |
| t_prepare | input | TW | Prepare phase count |
| t_zero | input | TW | Zero phase count |
| t_pre | input | TW | Clocking time before acknowledge |
| t_post | input | TW | Clocking time kept after release |
| t_trail | input | TW | Trail phase count |
| hs_en_sel | input | 1 | 1: high-speed enable from `hs_en_reg` |
| hs_en_reg | input | 1 | Forced high-speed enable value |
| lp_en_sel | input | 1 | 1: low-power enable from `lp_en_reg` |
| lp_en_reg | input | 1 | Forced low-power enable value |
| ana_hs_en | output | 1 | High-speed driver enable |
| ana_lp_en | output | 1 | Low-power driver enable |
| lane_status | output | 4 | {bias ready, idle, ultra-low-power, hs active} |

## Verification
The bench looks for off-by-one phase lengths. It changes every timing count and uses all-zero counts. A design that counted a phase one cycle short or long, or that skipped a phase of count zero, would move the high-speed enable edges or the acknowledge away from the cycles computed by the bench. It releases the request before the pre-interval ends, where a wrong design would still raise `hs_ack`. It raises a new request during the trail phase, where a wrong design would cut the trail short or skip the idle cycle. It also checks that power-down beats an active override and that both soft resets stop a lane that is clocking.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  localparam int unsigned TIME_W = 8;
  localparam int unsigned N_EN   = 2;
  localparam int unsigned EN_HS  = 0;
  localparam int unsigned EN_LP  = 1;

  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_LPX   = 3'd1,
    ST_PREP  = 3'd2,
    ST_ZERO  = 3'd3,
    ST_HSCLK = 3'd4,
    ST_POST  = 3'd5,
    ST_TRAIL = 3'd6
  } lane_st_e;
endpackage

// File: rtl/clk_lane_ivl.sv
// Phase interval counter: loaded on phase entry, counts down to 1 and holds.
module clk_lane_ivl #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      // a zero count still yields one cycle in the phase
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt > ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt <= ONE);
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
  import clk_lane_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_stop,
  input  logic          hs_req,
  input  logic          ivl_last,
  input  logic [TW-1:0] t_lpx,
  input  logic [TW-1:0] t_prepare,
  input  logic [TW-1:0] t_zero,
  input  logic [TW-1:0] t_pre,
  input  logic [TW-1:0] t_post,
  input  logic [TW-1:0] t_trail,
  output logic          ivl_clr,
  output logic          ivl_load,
  output logic [TW-1:0] ivl_val,
  output logic          fsm_hs_en,
  output logic          fsm_lp_en,
  output logic          hs_ack,
  output logic          tx_stop,
  output logic          hs_active
);
  lane_st_e state, nxt;
  logic     pre_done;

  always_comb begin
    nxt      = state;
    ivl_load = 1'b0;
    ivl_val  = '0;
    unique case (state)
      ST_STOP: if (hs_req) begin
        nxt = ST_LPX;   ivl_load = 1'b1; ivl_val = t_lpx;
      end
      ST_LPX: if (ivl_last) begin
        nxt = ST_PREP;  ivl_load = 1'b1; ivl_val = t_prepare;
      end
      ST_PREP: if (ivl_last) begin
        nxt = ST_ZERO;  ivl_load = 1'b1; ivl_val = t_zero;
      end
      ST_ZERO: if (ivl_last) begin
        nxt = ST_HSCLK; ivl_load = 1'b1; ivl_val = t_pre;
      end
      ST_HSCLK: if (!hs_req) begin
        nxt = ST_POST;  ivl_load = 1'b1; ivl_val = t_post;
      end
      ST_POST: if (ivl_last) begin
        nxt = ST_TRAIL; ivl_load = 1'b1; ivl_val = t_trail;
      end
      ST_TRAIL: if (ivl_last) begin
        nxt = ST_STOP;
      end
      default: nxt = ST_STOP;
    endcase
    if (hold_stop) begin
      nxt      = ST_STOP;
      ivl_load = 1'b0;
    end
  end

  assign ivl_clr = hold_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_STOP;
      pre_done <= 1'b0;
    end else begin
      state    <= nxt;
      pre_done <= (state == ST_HSCLK) && (nxt == ST_HSCLK) && (pre_done || ivl_last);
    end
  end

  assign hs_ack    = (state == ST_HSCLK) && pre_done;
  assign tx_stop   = (state == ST_STOP);
  assign fsm_lp_en = (state == ST_STOP) || (state == ST_LPX);
  assign hs_active = (state == ST_PREP) || (state == ST_ZERO) || (state == ST_HSCLK) ||
                     (state == ST_POST) || (state == ST_TRAIL);
  assign fsm_hs_en = hs_active;
endmodule

// File: rtl/clk_lane_drv.sv
// Per-enable source select with power-down gating.
module clk_lane_drv #(
  parameter int unsigned N = 2
) (
  input  logic         pwr_down,
  input  logic [N-1:0] fsm_en,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] regv,
  output logic [N-1:0] ana_en
);
  for (genvar g = 0; g < N; g++) begin : g_en
    assign ana_en[g] = !pwr_down && (sel[g] ? regv[g] : fsm_en[g]);
  end
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int unsigned TW = TIME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_lane,
  input  logic          soft_rst_phy,
  input  logic          pwr_down,
  input  logic          bias_ready,
  input  logic          hs_req,
  output logic          hs_ack,
  input  logic [TW-1:0] t_lpx,
  input  logic [TW-1:0] t_prepare,
  input  logic [TW-1:0] t_zero,
  input  logic [TW-1:0] t_pre,
  input  logic [TW-1:0] t_post,
  input  logic [TW-1:0] t_trail,
  input  logic          hs_en_sel,
  input  logic          hs_en_reg,
  input  logic          lp_en_sel,
  input  logic          lp_en_reg,
  output logic          ana_hs_en,
  output logic          ana_lp_en,
  output logic [3:0]    lane_status
);
  logic          hold_stop;
  logic          ivl_clr, ivl_load, ivl_last;
  logic [TW-1:0] ivl_val;
  logic          fsm_hs_en, fsm_lp_en, tx_stop, hs_active;
  logic [N_EN-1:0] fsm_en, en_sel, en_reg, ana_en;

  assign hold_stop = soft_rst_lane || soft_rst_phy || pwr_down;

  clk_lane_ivl #(.W(TW)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ivl_clr),
    .load     (ivl_load),
    .load_val (ivl_val),
    .last     (ivl_last)
  );

  clk_lane_fsm #(.TW(TW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_stop (hold_stop),
    .hs_req    (hs_req),
    .ivl_last  (ivl_last),
    .t_lpx     (t_lpx),
    .t_prepare (t_prepare),
    .t_zero    (t_zero),
    .t_pre     (t_pre),
    .t_post    (t_post),
    .t_trail   (t_trail),
    .ivl_clr   (ivl_clr),
    .ivl_load  (ivl_load),
    .ivl_val   (ivl_val),
    .fsm_hs_en (fsm_hs_en),
    .fsm_lp_en (fsm_lp_en),
    .hs_ack    (hs_ack),
    .tx_stop   (tx_stop),
    .hs_active (hs_active)
  );

  always_comb begin
    fsm_en[EN_HS] = fsm_hs_en;
    fsm_en[EN_LP] = fsm_lp_en;
    en_sel[EN_HS] = hs_en_sel;
    en_sel[EN_LP] = lp_en_sel;
    en_reg[EN_HS] = hs_en_reg;
    en_reg[EN_LP] = lp_en_reg;
  end

  clk_lane_drv #(.N(N_EN)) u_drv (
    .pwr_down (pwr_down),
    .fsm_en   (fsm_en),
    .sel      (en_sel),
    .regv     (en_reg),
    .ana_en   (ana_en)
  );

  assign ana_hs_en   = ana_en[EN_HS];
  assign ana_lp_en   = ana_en[EN_LP];
  assign lane_status = {bias_ready, tx_stop, 1'b0, hs_active};
endmodule

// File: rtl/clk_lane_seq_chk.sv
module clk_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst_lane,
  input logic       soft_rst_phy,
  input logic       pwr_down,
  input logic       hs_req,
  input logic       hs_ack,
  input logic       hs_en_sel,
  input logic       lp_en_sel,
  input logic       ana_hs_en,
  input logic       ana_lp_en,
  input logic [3:0] lane_status
);
  // R9
  pwr_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!ana_hs_en && !ana_lp_en));

  // R10
  soft_rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_lane || soft_rst_phy) |=> (lane_status[2] && !hs_ack));

  // R11
  idle_hs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane_status[2] && lane_status[0]));

  // R3
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_ack) |-> hs_req);

  // R3
  ack_clock_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ack && !hs_en_sel && !pwr_down) |-> ana_hs_en);

  // R1
  idle_lp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_status[2] && !lp_en_sel && !pwr_down) |-> ana_lp_en);
endmodule

bind clk_lane_seq clk_lane_seq_chk u_chk (.*);

// File: tb/clk_lane_seq_tb_top.sv
module clk_lane_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_lane = 0, soft_rst_phy = 0, pwr_down = 0, bias_ready = 0, hs_req = 0;
  logic hs_en_sel = 0, hs_en_reg = 0, lp_en_sel = 0, lp_en_reg = 0;
  logic [TW-1:0] t_lpx = 1, t_prepare = 1, t_zero = 1, t_pre = 1, t_post = 1, t_trail = 1;
  logic hs_ack, ana_hs_en, ana_lp_en;
  logic [3:0] lane_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_lane_seq dut_i (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int code; int at; } ev_t;
  ev_t exp_q[$];
  int n_chk = 0, n_bad = 0, stop_at = 0;
  string tag = "R1";
  bit mon_on = 0;
  logic p_hs, p_lp, p_ack;

  // event codes: 0 hs rise, 1 hs fall, 2 lp rise, 3 lp fall, 4 ack rise, 5 ack fall
  function automatic string ev_req(int code);
    if (code == 4 || code == 5) return "R3";
    if (code == 1 || code == 2) return "R4";
    return "R2";
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic expect_ev(int code, int at);
    exp_q.push_back('{code, at});
  endtask

  task automatic see(int code);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL %s/%s: unexpected event %0d at cycle %0d, expected none", ev_req(code), tag, code, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.code != code || e.at != cyc) begin
        n_bad++;
        $display("FAIL %s/%s: actual event %0d at cycle %0d, expected event %0d at cycle %0d",
                 ev_req(e.code), tag, code, cyc, e.code, e.at);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (ana_hs_en !== p_hs) see(ana_hs_en ? 0 : 1);
      if (ana_lp_en !== p_lp) see(ana_lp_en ? 2 : 3);
      if (hs_ack !== p_ack)   see(hs_ack ? 4 : 5);
    end
    p_hs  = ana_hs_en;
    p_lp  = ana_lp_en;
    p_ack = hs_ack;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: one request/release cycle, expected edges pushed to the scoreboard
  task automatic burst(string tg, int l, int pr, int z, int pe, int po, int tr, int hold, int lead);
    int lq, prq, zq, peq, poq, trq, p0, e_lpx, e_prep, e_hs, ack_at, r0, post_at;
    while (cyc < stop_at - lead) @(negedge clk);
    tag = tg;
    t_lpx = TW'(l); t_prepare = TW'(pr); t_zero = TW'(z);
    t_pre = TW'(pe); t_post = TW'(po); t_trail = TW'(tr);
    hs_req = 1'b1;
    p0  = cyc;
    lq  = (l  == 0) ? 1 : l;  prq = (pr == 0) ? 1 : pr; zq  = (z  == 0) ? 1 : z;
    peq = (pe == 0) ? 1 : pe; poq = (po == 0) ? 1 : po; trq = (tr == 0) ? 1 : tr;
    e_lpx  = imax(p0, stop_at) + 1;
    e_prep = e_lpx + lq;
    expect_ev(0, e_prep);
    expect_ev(3, e_prep);
    e_hs    = e_prep + prq + zq;
    r0      = p0 + hold;
    post_at = imax(r0, e_hs) + 1;
    ack_at  = e_hs + peq;
    if (ack_at < post_at) begin
      expect_ev(4, ack_at);
      expect_ev(5, post_at);
    end
    expect_ev(1, post_at + poq + trq);
    expect_ev(2, post_at + poq + trq);
    while (cyc < r0) @(negedge clk);
    if (r0 > e_hs) chk("R11", "status while clocking", lane_status, {bias_ready, 3'b001});
    hs_req  = 1'b0;
    stop_at = post_at + poq + trq;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle after reset
    chk("R1", "lp_en", ana_lp_en, 1);
    chk("R1", "hs_en", ana_hs_en, 0);
    chk("R1", "ack", hs_ack, 0);
    chk("R11", "status bias low", lane_status, 4'b0100);
    bias_ready = 1'b1;
    #1 chk("R11", "status bias high", lane_status, 4'b1100);
    @(negedge clk);

    mon_on  = 1;
    stop_at = cyc;
    burst("R2", 2, 3, 4, 2, 3, 2, 20, 0);
    burst("R5", 0, 0, 0, 0, 0, 0, 10, 0);
    burst("R3", 1, 1, 1, 10, 2, 2, 5, 0);
    burst("R4", 1, 2, 2, 1, 2, 4, 15, 0);
    burst("R6", 3, 1, 1, 2, 1, 1, 20, 2);
    while (cyc <= stop_at + 3) @(negedge clk);
    chk("R4", "leftover expected events", exp_q.size(), 0);
    mon_on = 0;
    t_lpx = 1; t_prepare = 1; t_zero = 1; t_pre = 1; t_post = 1; t_trail = 1;

    // R7 high-speed override
    hs_en_sel = 1; hs_en_reg = 1;
    #1 chk("R7", "forced hs on", ana_hs_en, 1);
    chk("R7", "idle kept under override", lane_status[2], 1);
    hs_en_reg = 0;
    #1 chk("R7", "forced hs off", ana_hs_en, 0);
    hs_en_sel = 0;
    // R8 low-power override
    lp_en_sel = 1; lp_en_reg = 0;
    #1 chk("R8", "forced lp off", ana_lp_en, 0);
    lp_en_reg = 1;
    #1 chk("R8", "forced lp on", ana_lp_en, 1);
    lp_en_sel = 0; lp_en_reg = 0;
    @(negedge clk);

    // R9 power-down during clocking
    hs_req = 1;
    repeat (10) @(negedge clk);
    chk("R3", "ack before power-down", hs_ack, 1);
    pwr_down = 1;
    #1 chk("R9", "hs off", ana_hs_en, 0);
    chk("R9", "lp off", ana_lp_en, 0);
    hs_en_sel = 1; hs_en_reg = 1;
    #1 chk("R9", "override beaten", ana_hs_en, 0);
    @(negedge clk);
    chk("R9", "idle after power-down", lane_status, 4'b1100);
    chk("R9", "ack dropped", hs_ack, 0);
    repeat (4) @(negedge clk);
    chk("R9", "request ignored", lane_status, 4'b1100);
    pwr_down = 0; hs_en_sel = 0; hs_en_reg = 0;
    repeat (10) @(negedge clk);
    chk("R9", "resume after power-up", hs_ack, 1);

    // R10 soft resets
    soft_rst_lane = 1;
    @(negedge clk);
    chk("R10", "lane reset idle", lane_status, 4'b1100);
    chk("R10", "lane reset lp", ana_lp_en, 1);
    chk("R10", "lane reset ack", hs_ack, 0);
    soft_rst_lane = 0;
    repeat (10) @(negedge clk);
    chk("R10", "restart after lane reset", hs_ack, 1);
    soft_rst_phy = 1;
    @(negedge clk);
    chk("R10", "phy reset idle", lane_status, 4'b1100);
    chk("R10", "phy reset hs", ana_hs_en, 0);
    soft_rst_phy = 0;
    hs_req = 0;
    repeat (10) @(negedge clk);
    chk("R1", "idle at end", {ana_hs_en, ana_lp_en, hs_ack}, 3'b010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule